// File: doc/BRIEF.md
# Serial Mode-Register Access Port

This block is a four-wire serial slave that lets a host controller read and write a bank of eight-bit mode registers. The host lowers the select line, then clocks a sixteen-bit frame. The first bit chooses read or write, the next seven bits name the register, and the last eight bits carry the data. The block runs in its own system clock domain. Its serial pins are expected to arrive already synchronized to that clock, and the block finds the serial clock edges by comparing the current and previous samples.

On a write, the addressed register changes only when the sixteenth rising edge of the frame is seen. On a read, the register value is shifted out MSB first, starting at the falling edge that closes the eighth bit. All register contents are presented in parallel to the rest of the chip. Each register comes out of reset with a value computed from its index.

Top module: `spi_regport`

## Requirements
- R1: A frame is 16 bits, MSB first, with spi_mosi sampled on rising spi_sck edges. Frame bit 15 is the direction (0 write, 1 read), bits 14:8 are the register index, and bits 7:0 are the data.
- R2: A write frame updates register `index` with bits 7:0 on the system clock edge that sees the sixteenth rising spi_sck edge. The register holds its old value until then.
- R3: In a read frame, spi_miso_oe goes high and spi_miso presents bit 7 of the addressed register on the falling edge after the eighth rising edge. The next bits follow, one per falling edge, MSB first.
- R4: spi_miso and spi_miso_oe stay low while spi_cs_n is high and during the first eight bits of any frame.
- R5: If spi_cs_n rises before the sixteenth rising edge, no register is changed.
- R6: Rising edges after the sixteenth are ignored until spi_cs_n returns high. A new frame then starts on the next low period.
- R7: On reset, register n holds (3*n + 1) mod 256.
- R8: A read frame leaves every register unchanged, whatever its data field holds.
- R9: A rising spi_sck edge sampled in the same system clock cycle that spi_cs_n is seen high is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low frame select, synchronized to clk |
| spi_sck | input | 1 | Serial clock, synchronized to clk |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial read data to host, low when not driving |
| spi_miso_oe | output | 1 | Output enable for spi_miso |
| mode_regs | output | NUM_REGS*DATA_W | All registers, register n at bits n*8+7 : n*8 |

## Verification
The sixteenth rising clock edge, which commits a write, can be sampled in the same system cycle as the select line going high, which ends the frame. The bench provokes this by raising spi_sck and spi_cs_n on the same clock. It then judges the result at the mode_regs port: one cycle later, the target register must still hold its reset value. The same frame, without the early deselect, gives the contrasting case. There the register value is captured just before and just after the commit edge, to pin the update to a single cycle.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;

  // Reset value of mode register idx; truncated by the caller to the data width.
  function automatic logic [31:0] reg_reset_value(input int unsigned idx);
    return 32'(3 * idx + 1);
  endfunction

  // Frame length for a given index width and data width.
  function automatic int frame_len(input int addr_w, input int data_w);
    return 1 + addr_w + data_w;
  endfunction

endpackage

// File: rtl/spi_pin_sampler.sv
module spi_pin_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  output logic sck_rise,
  output logic sck_fall
);
  logic sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck;
  end

  // Edges only count while the frame is selected in this very sample.
  assign sck_rise = sck & ~sck_q & ~cs_n;
  assign sck_fall = ~sck & sck_q & ~cs_n;

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_regport_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              wr_en,
  output logic [DATA_W-1:0] wr_data,
  output logic              miso,
  output logic              miso_oe
);
  localparam int FRAME_BITS = frame_len(ADDR_W, DATA_W);
  localparam int HDR_BITS   = 1 + ADDR_W;
  localparam int SH_W       = FRAME_BITS - 1;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  logic [CNT_W-1:0]  bit_cnt;
  logic [SH_W-1:0]   shreg;
  logic              hdr_rw;
  logic [ADDR_W-1:0] hdr_addr;
  logic [DATA_W-1:0] out_sh;
  logic              drive;

  // Named internal events.
  logic hdr_done, frame_done, rd_load, rd_shift;
  assign hdr_done   = sck_rise && (bit_cnt == CNT_W'(HDR_BITS - 1));
  assign frame_done = sck_rise && (bit_cnt == CNT_W'(FRAME_BITS - 1));
  assign rd_load    = sck_fall && hdr_rw && (bit_cnt == CNT_W'(HDR_BITS));
  assign rd_shift   = sck_fall && drive && (bit_cnt < CNT_W'(FRAME_BITS));

  assign reg_addr = hdr_addr;
  assign wr_en    = frame_done && !hdr_rw;
  assign wr_data  = {shreg[DATA_W-2:0], mosi};
  assign miso     = drive & out_sh[DATA_W-1];
  assign miso_oe  = drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      hdr_rw   <= 1'b0;
      hdr_addr <= '0;
      out_sh   <= '0;
      drive    <= 1'b0;
    end else if (cs_n) begin
      bit_cnt <= '0;
      hdr_rw  <= 1'b0;
      out_sh  <= '0;
      drive   <= 1'b0;
    end else begin
      if (sck_rise && (bit_cnt < CNT_W'(FRAME_BITS))) begin
        shreg   <= {shreg[SH_W-2:0], mosi};
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (hdr_done) begin
        hdr_rw   <= shreg[ADDR_W-1];
        hdr_addr <= {shreg[ADDR_W-2:0], mosi};
      end
      if (rd_load) begin
        out_sh <= rd_data;
        drive  <= 1'b1;
      end else if (rd_shift) begin
        out_sh <= {out_sh[DATA_W-2:0], 1'b0};
      end
    end
  end

  AST_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n)) |-> !miso_oe); // R4
  AST_QUIET_IN_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt < CNT_W'(HDR_BITS)) |-> !miso_oe); // R4
  AST_MISO_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!sck_fall && !cs_n) |=> $stable(miso)); // R3
  AST_COMMIT_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (bit_cnt == CNT_W'(FRAME_BITS))); // R2
  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_BITS)); // R6
  AST_DESELECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (bit_cnt == '0)); // R9

endmodule

// File: rtl/spi_mode_regs.sv
module spi_mode_regs
  import spi_regport_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 128
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [DATA_W-1:0]          rd_data,
  output logic [NUM_REGS*DATA_W-1:0] regs_flat
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= DATA_W'(reg_reset_value(g));
      else if (wr_en && (addr == ADDR_W'(g)))
        regs[g] <= wr_data;
    end
    assign regs_flat[g*DATA_W +: DATA_W] = regs[g];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (addr == ADDR_W'(i)) rd_data = regs[i];
  end

  AST_REGS_HOLD_WITHOUT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_flat)); // R5
  AST_COMMIT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data == $past(wr_data))); // R2

endmodule

// File: rtl/spi_regport.sv
module spi_regport #(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 128
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       spi_cs_n,
  input  logic                       spi_sck,
  input  logic                       spi_mosi,
  output logic                       spi_miso,
  output logic                       spi_miso_oe,
  output logic [NUM_REGS*DATA_W-1:0] mode_regs
);
  logic              sck_rise, sck_fall;
  logic [ADDR_W-1:0] reg_addr;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data, rd_data;

  spi_pin_sampler u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (spi_cs_n),
    .sck      (spi_sck),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall)
  );

  spi_frame_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (spi_cs_n),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .mosi     (spi_mosi),
    .rd_data  (rd_data),
    .reg_addr (reg_addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .miso     (spi_miso),
    .miso_oe  (spi_miso_oe)
  );

  spi_mode_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (reg_addr),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .regs_flat (mode_regs)
  );

  AST_NO_WRITE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !wr_en); // R9

endmodule

// File: tb/test_spi_regport.sv
module test_spi_regport;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, oe;
  logic [128*8-1:0] regs;

  spi_regport i_spi_regport (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(oe), .mode_regs(regs)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nvec = 0, nfail = 0;
  bit done = 1'b0;
  logic [7:0] rd, pre_v, post_v;
  int early_oe, late_noe;

  // {rw, index, data, expected read}
  localparam logic [23:0] VEC [10] = '{
    {1'b0, 7'h12, 8'hA5, 8'h00},
    {1'b0, 7'h7F, 8'h3C, 8'h00},
    {1'b0, 7'h00, 8'hFF, 8'h00},
    {1'b1, 7'h12, 8'h00, 8'hA5},
    {1'b1, 7'h7F, 8'h00, 8'h3C},
    {1'b1, 7'h00, 8'h00, 8'hFF},
    {1'b1, 7'h40, 8'h00, 8'hC1},
    {1'b1, 7'h55, 8'h99, 8'h00},
    {1'b0, 7'h01, 8'h00, 8'h00},
    {1'b1, 7'h01, 8'h5A, 8'h00}
  };

  function automatic logic [7:0] dflt(input int n);
    int s = n + n + n + 1;
    return s[7:0];
  endfunction

  function automatic logic [7:0] reg_at(input logic [6:0] a);
    return regs[int'(a)*8 +: 8];
  endfunction

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic frame(input logic rw, input logic [6:0] addr, input logic [7:0] data,
                       input int nclk, input bit cs_with_last);
    logic [15:0] w = {rw, addr, data};
    rd = '0; early_oe = 0; late_noe = 0; pre_v = '0; post_v = '0;
    @(negedge clk); cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      mosi = (i < 16) ? w[15-i] : 1'b1;
      sck  = 1'b0;
      repeat (HALF) @(negedge clk);
      if (i < 8 && oe) early_oe++;
      if (i >= 8 && i < 16) begin
        rd = {rd[6:0], miso};
        if (rw && !oe) late_noe++;
      end
      if (i == 15) pre_v = reg_at(addr);
      sck = 1'b1;
      if (cs_with_last && i == nclk - 1) cs_n = 1'b1;
      @(negedge clk);
      if (i == 15) post_v = reg_at(addr);
      repeat (HALF - 1) @(negedge clk);
    end
    sck = 1'b0;
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
    if (oe || miso) early_oe++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    check("R4", "idle miso", {7'd0, miso}, 8'h00);
    check("R4", "idle oe", {7'd0, oe}, 8'h00);
    bad = 0;
    for (int n = 0; n < 128; n++) if (regs[n*8 +: 8] !== dflt(n)) bad++;
    check("R7", "reset defaults mismatching", 8'(bad), 8'h00);

    // Vector table (frame layout R1)
    for (int v = 0; v < 10; v++) begin
      frame(VEC[v][23], VEC[v][22:16], VEC[v][15:8], 16, 1'b0);
      check("R4", "oe in header or idle", 8'(early_oe), 8'h00);
      if (!VEC[v][23]) begin
        check("R1", "written register", reg_at(VEC[v][22:16]), VEC[v][15:8]);
      end else begin
        check("R3", "read data", rd, VEC[v][7:0]);
        check("R3", "oe gaps in data phase", 8'(late_noe), 8'h00);
        check("R8", "register after read", reg_at(VEC[v][22:16]), VEC[v][7:0]);
      end
    end

    // R2: commit exactly on the sixteenth rising edge
    frame(1'b0, 7'h30, 8'h5E, 16, 1'b0);
    check("R2", "before commit", pre_v, dflt(8'h30));
    check("R2", "one cycle after commit", post_v, 8'h5E);

    // R5: aborted frames
    frame(1'b0, 7'h20, 8'h11, 12, 1'b0);
    check("R5", "abort after 12", reg_at(7'h20), dflt(8'h20));
    frame(1'b0, 7'h21, 8'h11, 15, 1'b0);
    check("R5", "abort after 15", reg_at(7'h21), dflt(8'h21));

    // R9: sixteenth edge coincides with deselect
    frame(1'b0, 7'h22, 8'h77, 16, 1'b1);
    check("R9", "coincident deselect post", post_v, dflt(8'h22));
    check("R9", "coincident deselect final", reg_at(7'h22), dflt(8'h22));

    // R6: extra clocks ignored, next frame works
    frame(1'b0, 7'h23, 8'h3A, 20, 1'b0);
    check("R6", "write with extra clocks", reg_at(7'h23), 8'h3A);
    frame(1'b1, 7'h23, 8'h00, 20, 1'b0);
    check("R6", "read with extra clocks", rd, 8'h3A);
    check("R4", "oe outside data phase", 8'(early_oe), 8'h00);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule